// File: doc/BRIEF.md
# Two-Wire Serial Bus Slave Controller

This block is the slave end of a two-wire serial bus, the kind known as I2C. The bus master drives the clock line. The data line is shared and open-drain. The slave never drives either line high. It only pulls the data line low, through an output-enable. Both line inputs are sampled by a much faster system clock. Each input passes through a synchroniser and a majority-free glitch filter, and only then does the block look for clock edges and for START and STOP conditions.

After a START on a free bus, the slave shifts in one address byte and answers with ACK only when the address matches its parameter. It then acts as a receiver or as a transmitter toward a simple byte-wide register port, which has a pointer, a write strobe with write data, and a read-data input. In a write, the first data byte sets the pointer, and each later byte is presented with a write strobe. In a read, the slave sends the byte found at the pointer. The pointer advances after every data byte.

The slave does not accept a repeated START. A START that arrives before the STOP that ends the current transfer aborts that transfer. The slave then ignores the bus until a STOP is seen.

Top module: `twb_slave`

## Requirements
- R1: After reset, `line_dt_pull` is 0, `reg_wr` is 0 and `reg_ptr` is 0.
- R2: Each line input changes its filtered value only after three consecutive equal synchronised samples. A data-line dip of two system clocks while the clock line is high therefore never starts a transfer.
- R3: With the bus free, a falling data line while the clock line is high begins an address phase. A rising data line while the clock line is high ends any transfer and frees the bus.
- R4: The address byte carries the 7-bit address MSB first in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The slave pulls the data line low during the ninth clock only when bits 7..1 equal `SLV_ADDR` (default 7'h52, so 0xA4 writes and 0xA5 reads). On a mismatch the slave leaves the line released until a STOP.
- R5: In a write, the first data byte loads `reg_ptr`, is acknowledged, and raises no write strobe.
- R6: Each later written byte is acknowledged. It also raises `reg_wr` for exactly one system clock, with `reg_wdata` holding the byte and `reg_ptr` holding its target.
- R7: `reg_ptr` advances by one, modulo 256, after every data byte that is written with a strobe or read out.
- R8: In a read, the slave sends `reg_rdata` at the current pointer MSB first and releases the line in the ninth clock. It continues with the next byte after an ACK. After a NACK it leaves the line released until a STOP.
- R9: A START seen while the bus is not free (no STOP since the last START) aborts the transfer. No further ACK and no strobe follow until a STOP, and the next transfer after the STOP works normally.
- R10: The slave begins pulling the data line low only while the filtered clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_ck_i | input | 1 | Bus clock line level |
| line_dt_i | input | 1 | Bus data line level (wired value, including this slave's pull) |
| line_dt_pull | output | 1 | 1 = pull the data line low; 0 = release it |
| reg_wr | output | 1 | One-cycle write strobe toward the register port |
| reg_ptr | output | DW | Register pointer (write target and read address) |
| reg_wdata | output | DW | Write data, valid while `reg_wr` is 1 |
| reg_rdata | input | DW | Read data at `reg_ptr`, supplied by the register port |

## Verification
The bound checker watches four things on every cycle. The write strobe lasts one clock. The pointer advances right after each strobe. The data line is first pulled low only while the filtered clock is low. An illegal START is followed neither by a pull nor by a strobe. The bench's directed master is needed for the rest, which depends on whole bus sequences. That covers acknowledgement depending on the address, and the pointer load by the first written byte. It also covers the bytes transmitted in a read and the release after a NACK. Finally it covers rejection of a glitch and of a repeated START, and recovery after the following STOP.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } twb_state_e;
endpackage

// File: rtl/twb_filter.sv
module twb_filter #(
  parameter int SYNC = 2,
  parameter int WIN  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  logic [SYNC-1:0] sync_q;
  logic [WIN-1:0]  win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      win_q  <= '1;
      filt   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], raw};
      win_q  <= {win_q[WIN-2:0], sync_q[SYNC-1]};
      if (&win_q)
        filt <= 1'b1;
      else if (~|win_q)
        filt <= 1'b0;
    end
  end
endmodule

// File: rtl/twb_cond.sv
module twb_cond (
  input  logic clk,
  input  logic rst,
  input  logic ck,
  input  logic dt,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic ck_q, dt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q <= 1'b1;
      dt_q <= 1'b1;
    end else begin
      ck_q <= ck;
      dt_q <= dt;
    end
  end

  always_comb begin
    start_p = ck & ck_q & dt_q & ~dt;
    stop_p  = ck & ck_q & ~dt_q & dt;
    rise_p  = ck & ~ck_q;
    fall_p  = ~ck & ck_q;
  end
endmodule

// File: rtl/twb_engine.sv
module twb_engine
  import twb_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-2:0] SLV_ADDR = 7'h52
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dt,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          rise_p,
  input  logic          fall_p,
  input  logic [DW-1:0] rdata,
  output logic          pull,
  output logic          wr,
  output logic [DW-1:0] ptr,
  output logic [DW-1:0] wdata,
  output logic          bus_free
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  twb_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [DW-1:0] tx;
  logic          rd_q;
  logic          ptr_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      rd_q     <= 1'b0;
      ptr_set  <= 1'b0;
      pull     <= 1'b0;
      wr       <= 1'b0;
      ptr      <= '0;
      wdata    <= '0;
      bus_free <= 1'b1;
    end else begin
      wr <= 1'b0;
      if (wr)
        ptr <= ptr + 1'b1;
      if (stop_p) begin
        state    <= ST_IDLE;
        bus_free <= 1'b1;
        pull     <= 1'b0;
      end else if (start_p) begin
        pull <= 1'b0;
        cnt  <= '0;
        if (bus_free) begin
          state    <= ST_ADDR;
          bus_free <= 1'b0;
        end else begin
          state <= ST_IDLE;
        end
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (rise_p) begin
              sh  <= {sh[DW-2:0], dt};
              cnt <= cnt + 1'b1;
            end else if (fall_p && cnt == LAST) begin
              cnt <= '0;
              if (sh[DW-1:1] == SLV_ADDR) begin
                pull    <= 1'b1;
                rd_q    <= sh[0];
                ptr_set <= 1'b0;
                state   <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (fall_p) begin
              if (rd_q) begin
                tx    <= rdata;
                pull  <= ~rdata[DW-1];
                state <= ST_RBYTE;
              end else begin
                pull  <= 1'b0;
                state <= ST_WBYTE;
              end
            end
          end
          ST_WBYTE: begin
            if (rise_p) begin
              sh  <= {sh[DW-2:0], dt};
              cnt <= cnt + 1'b1;
            end else if (fall_p && cnt == LAST) begin
              cnt   <= '0;
              pull  <= 1'b1;
              state <= ST_WACK;
              if (ptr_set) begin
                wr    <= 1'b1;
                wdata <= sh;
              end else begin
                ptr     <= sh;
                ptr_set <= 1'b1;
              end
            end
          end
          ST_WACK: begin
            if (fall_p) begin
              pull  <= 1'b0;
              state <= ST_WBYTE;
            end
          end
          ST_RBYTE: begin
            if (rise_p) begin
              cnt <= cnt + 1'b1;
            end else if (fall_p) begin
              if (cnt == LAST) begin
                cnt   <= '0;
                pull  <= 1'b0;
                ptr   <= ptr + 1'b1;
                state <= ST_RACK;
              end else begin
                tx   <= {tx[DW-2:0], 1'b0};
                pull <= ~tx[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (rise_p) begin
              if (dt)
                state <= ST_IDLE;
            end else if (fall_p) begin
              tx    <= rdata;
              pull  <= ~rdata[DW-1];
              state <= ST_RBYTE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/twb_slave.sv
module twb_slave #(
  parameter int            DW          = 8,
  parameter logic [DW-2:0] SLV_ADDR    = 7'h52,
  parameter int            SYNC_STAGES = 2,
  parameter int            FILT_LEN    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_ck_i,
  input  logic          line_dt_i,
  output logic          line_dt_pull,
  output logic          reg_wr,
  output logic [DW-1:0] reg_ptr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_v;
  logic [NLINES-1:0] filt_v;
  logic ck_f, dt_f;
  logic start_p, stop_p, rise_p, fall_p;
  logic bus_free;

  assign raw_v = {line_dt_i, line_ck_i};
  assign ck_f  = filt_v[0];
  assign dt_f  = filt_v[1];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    twb_filter #(.SYNC(SYNC_STAGES), .WIN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_v[g]),
      .filt (filt_v[g])
    );
  end

  twb_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .ck      (ck_f),
    .dt      (dt_f),
    .start_p (start_p),
    .stop_p  (stop_p),
    .rise_p  (rise_p),
    .fall_p  (fall_p)
  );

  twb_engine #(.DW(DW), .SLV_ADDR(SLV_ADDR)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .dt       (dt_f),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .rdata    (reg_rdata),
    .pull     (line_dt_pull),
    .wr       (reg_wr),
    .ptr      (reg_ptr),
    .wdata    (reg_wdata),
    .bus_free (bus_free)
  );
endmodule

// File: rtl/twb_slave_chk.sv
module twb_slave_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ck_f,
  input logic          start_p,
  input logic          bus_free,
  input logic          dt_pull,
  input logic          reg_wr,
  input logic [DW-1:0] reg_ptr
);
  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> reg_ptr == DW'($past(reg_ptr) + 1'b1));

  // R10
  pull_ck_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dt_pull) |-> !ck_f);

  // R9
  rep_start_pull_chk: assert property (@(posedge clk) disable iff (rst)
    (start_p && !bus_free) |=> !dt_pull);

  // R9
  rep_start_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (start_p && !bus_free) |=> !reg_wr);
endmodule

bind twb_slave twb_slave_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ck_f     (ck_f),
  .start_p  (start_p),
  .bus_free (bus_free),
  .dt_pull  (line_dt_pull),
  .reg_wr   (reg_wr),
  .reg_ptr  (reg_ptr)
);

// File: tb/sim_twb_slave.sv
`timescale 1ns/1ps
module sim_twb_slave;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_ck = 1'b1;
  logic       m_dt = 1'b1;
  logic       line_dt_pull;
  logic       reg_wr;
  logic [7:0] reg_ptr, reg_wdata, reg_rdata;
  logic       line_dt;
  logic [7:0] mem [256];
  int         wr_count = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  assign line_dt   = m_dt & ~line_dt_pull;
  assign reg_rdata = mem[reg_ptr];

  twb_slave u0 (
    .clk          (clk),
    .rst          (rst),
    .line_ck_i    (m_ck),
    .line_dt_i    (line_dt),
    .line_dt_pull (line_dt_pull),
    .reg_wr       (reg_wr),
    .reg_ptr      (reg_ptr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata)
  );

  always @(posedge clk) begin
    if (!rst && reg_wr) begin
      mem[reg_ptr] <= reg_wdata;
      wr_count     <= wr_count + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_dt = 1'b1; wq(); m_ck = 1'b1; wq();
    m_dt = 1'b0; wq(); m_ck = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_dt = 1'b0; wq(); m_ck = 1'b1; wq(); m_dt = 1'b1; wq();
  endtask

  task automatic send_bit(input bit b);
    m_dt = b; wq(); m_ck = 1'b1; wq(); wq(); m_ck = 1'b0; wq();
  endtask

  task automatic recv_bit(output bit b);
    m_dt = 1'b1; wq(); m_ck = 1'b1; wq(); b = line_dt; wq(); m_ck = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!give_ack);
  endtask

  task automatic t_reset();
    check(line_dt_pull == 1'b0, "R1 pull", line_dt_pull, 0);
    check(reg_wr == 1'b0, "R1 wr", reg_wr, 0);
    check(reg_ptr == 8'h00, "R1 ptr", reg_ptr, 0);
  endtask

  task automatic t_glitch();
    bit ak;
    m_dt = 1'b0; repeat (2) @(negedge clk); m_dt = 1'b1;
    wq(); m_ck = 1'b0; wq();
    send_byte(8'hA4, ak);
    check(ak == 1'b0, "R2 glitch gave no start", ak, 0);
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit ak;
    int w0 = wr_count;
    bus_start();
    send_byte(8'h26, ak);
    check(ak == 1'b0, "R4 mismatch nack", ak, 0);
    send_byte(8'h33, ak);
    check(ak == 1'b0, "R4 silent after mismatch", ak, 0);
    bus_stop();
    check(wr_count == w0, "R4 no strobe", wr_count, w0);
  endtask

  task automatic t_write();
    bit ak;
    int w0 = wr_count;
    bus_start();
    send_byte(8'hA4, ak);
    check(ak == 1'b1, "R3 start on free bus / R4 address ack", ak, 1);
    send_byte(8'h10, ak);
    check(ak == 1'b1, "R5 pointer byte ack", ak, 1);
    check(wr_count == w0, "R5 no strobe for pointer", wr_count, w0);
    check(reg_ptr == 8'h10, "R5 pointer loaded", reg_ptr, 8'h10);
    send_byte(8'hA1, ak); check(ak, "R6 data ack", ak, 1);
    send_byte(8'hB2, ak); check(ak, "R6 data ack", ak, 1);
    send_byte(8'hC3, ak); check(ak, "R6 data ack", ak, 1);
    bus_stop();
    check(wr_count == w0 + 3, "R6 strobe count", wr_count, w0 + 3);
    check(mem[8'h10] == 8'hA1, "R6 byte0", mem[8'h10], 8'hA1);
    check(mem[8'h11] == 8'hB2, "R6 byte1", mem[8'h11], 8'hB2);
    check(mem[8'h12] == 8'hC3, "R6 byte2", mem[8'h12], 8'hC3);
    check(reg_ptr == 8'h13, "R7 pointer after write", reg_ptr, 8'h13);
  endtask

  task automatic t_wrap();
    bit ak;
    bus_start();
    send_byte(8'hA4, ak);
    send_byte(8'hFF, ak);
    send_byte(8'h5A, ak);
    send_byte(8'h6B, ak);
    bus_stop();
    check(mem[8'hFF] == 8'h5A, "R7 wrap byte at FF", mem[8'hFF], 8'h5A);
    check(mem[8'h00] == 8'h6B, "R7 wrap byte at 00", mem[8'h00], 8'h6B);
    check(reg_ptr == 8'h01, "R7 pointer wrapped", reg_ptr, 8'h01);
  endtask

  task automatic t_read();
    bit ak, b;
    logic [7:0] v;
    bus_start();
    send_byte(8'hA4, ak);
    send_byte(8'h10, ak);
    bus_stop();
    bus_start();
    send_byte(8'hA5, ak);
    check(ak == 1'b1, "R4 read address ack", ak, 1);
    recv_byte(1'b1, v); check(v == 8'hA1, "R8 read byte0", v, 8'hA1);
    recv_byte(1'b1, v); check(v == 8'hB2, "R8 read byte1", v, 8'hB2);
    recv_byte(1'b0, v); check(v == 8'hC3, "R8 read byte2", v, 8'hC3);
    recv_bit(b);
    check(b == 1'b1, "R8 released after nack", b, 1);
    bus_stop();
    check(reg_ptr == 8'h13, "R7 pointer after read", reg_ptr, 8'h13);
  endtask

  task automatic t_repstart();
    bit ak;
    int w0 = wr_count;
    bus_start();
    send_byte(8'hA4, ak);
    send_byte(8'h20, ak);
    send_byte(8'h77, ak);
    bus_start();
    send_byte(8'hA4, ak);
    check(ak == 1'b0, "R9 repeated start not acked", ak, 0);
    send_byte(8'h88, ak);
    check(ak == 1'b0, "R9 data after abort not acked", ak, 0);
    bus_stop();
    check(wr_count == w0 + 1, "R9 no strobe after abort", wr_count, w0 + 1);
    check(mem[8'h21] == 8'h00, "R9 target untouched", mem[8'h21], 0);
    bus_start();
    send_byte(8'hA4, ak);
    check(ak == 1'b1, "R9 recovery after stop", ak, 1);
    send_byte(8'h21, ak);
    send_byte(8'h99, ak);
    bus_stop();
    check(mem[8'h21] == 8'h99, "R9 recovery write", mem[8'h21], 8'h99);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_glitch();
    t_mismatch();
    t_write();
    t_wrap();
    t_read();
    t_repstart();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule